// File: doc/BRIEF.md
# Carry-Free Signed-Digit Modulo 2^n-1 / 2^n+1 Adder

This block adds two n-digit radix-2 signed-digit words and returns their sum reduced modulo 2^n-1 or 2^n+1. The modulus is chosen by a parameter. Each digit is one of -1, 0 or +1 and travels on a pair of wires, a negative bit and a positive bit. The block is purely combinational. Every result digit is formed from a small window of neighbouring input digits, so the logic depth is the same for any word length.

The reduction is an end-around transfer. The transfer leaving the top digit re-enters digit 0. For 2^n-1 it re-enters unchanged. For 2^n+1 it re-enters negated, and the lookahead for digit 0 is built from the positive bits of the top digit. This keeps the 2^n+1 result within n digits: a sum above 2^n-1 comes out as a congruent negative value. The result is not reduced to a canonical value. Any output that is congruent to the true sum is correct.

The block is meant to sit inside residue-arithmetic datapaths that keep operands in redundant form. Conversion to binary is left to a separate stage.

Top module: `sd_mod_adder`

## Requirements
- R1: For legal inputs (no digit coded 11), every output digit is legal. Digit codes are (negative bit, positive bit): 00 is 0, 01 is +1, 10 is -1. Inside the block, the transfer entering a position and that position's interim digit never have the same nonzero sign.
- R2: With MOD_PLUS=0, the word value of the output is congruent to the sum of the input word values modulo 2^DIGITS-1. A word's value is the unsigned value of the positive-bit vector minus the unsigned value of the negative-bit vector.
- R3: With MOD_PLUS=1, the word value of the output is congruent to the sum of the input word values modulo 2^DIGITS+1.
- R4: When both operands are all-zero, every output digit is exactly 0 (sum_neg and sum_pos all zero), for either modulus.
- R5: With MOD_PLUS=1 and DIGITS=3, adding +6 (positive bits 110) and +2 (positive bits 010) gives exactly -1: sum_neg=001 and sum_pos=000.
- R6: Output digit i depends only on input digits i, i-1 and i-2, with indices taken modulo DIGITS. Changing one input digit j leaves every output digit outside j, j+1 and j+2 (modulo DIGITS) unchanged.
- R7: With MOD_PLUS=0 and DIGITS=3, adding +4 and +4 (positive bits 100 each) gives exactly +1: the top transfer re-enters at digit 0, so sum_pos=001 and sum_neg=000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_neg | input | DIGITS | Negative bits of operand A, bit i is digit i |
| a_pos | input | DIGITS | Positive bits of operand A |
| b_neg | input | DIGITS | Negative bits of operand B |
| b_pos | input | DIGITS | Positive bits of operand B |
| sum_neg | output | DIGITS | Negative bits of the modular sum |
| sum_pos | output | DIGITS | Positive bits of the modular sum |

## Verification
Two functions can be active on the same input: the ordinary position-to-position transfer, and the end-around transfer out of the top digit into digit 0. Several cases make both happen at once. These are operands whose top digits sum to plus or minus two, top-digit pairs of plus or minus one whose lookahead comes from the wrapped neighbour, and the exhaustive sweep of every legal 3-digit pair under both moduli. Each result is judged by decoding the output to an integer and checking congruence with the decoded operand sum. Directed cases also pin the exact digits of the wrapped sum for one example under each modulus.

// File: rtl/sd_mod_pkg.sv
// Shared types and helpers for the signed-digit modulo adder.
// Assumes digit code 11 never appears on a legal operand.
package sd_mod_pkg;

    // One signed digit: neg=1 means -1, pos=1 means +1, both 0 means 0.
    typedef struct packed {
        logic neg;
        logic pos;
    } sd_digit_t;

    // Classification of the sum of the two operand digits at one position.
    typedef enum logic [2:0] {
        PAIR_ZERO = 3'd0,
        PAIR_P1   = 3'd1,
        PAIR_P2   = 3'd2,
        PAIR_M1   = 3'd3,
        PAIR_M2   = 3'd4
    } pair_class_t;

    localparam sd_digit_t SD_ZERO = '{neg: 1'b0, pos: 1'b0};
    localparam sd_digit_t SD_PLUS = '{neg: 1'b0, pos: 1'b1};
    localparam sd_digit_t SD_MINUS = '{neg: 1'b1, pos: 1'b0};

    // Negate a digit by swapping its two bits.
    function automatic sd_digit_t sd_negate(input sd_digit_t d);
        sd_negate = '{neg: d.pos, pos: d.neg};
    endfunction

    // Integer value of a word held as two bit vectors (used by checks only).
    function automatic longint sd_word_value(input logic [63:0] neg_bits,
                                             input logic [63:0] pos_bits);
        longint acc;
        acc = 0;
        for (int k = 0; k < 64; k++) begin
            if (pos_bits[k]) acc = acc + (longint'(1) <<< k);
            if (neg_bits[k]) acc = acc - (longint'(1) <<< k);
        end
        sd_word_value = acc;
    endfunction

endpackage

// File: rtl/sd_pos_split.sv
// Per-position split: from the two operand digits and the lookahead flag
// (at least one digit one position lower is negative), forms the transfer
// digit sent up one position and the interim digit kept here.
// Assumes legal digit codes on both operands.
module sd_pos_split
    import sd_mod_pkg::*;
(
    input  sd_digit_t x_dig,
    input  sd_digit_t y_dig,
    input  logic      lower_neg,
    output sd_digit_t xfer_out,
    output sd_digit_t interim
);

    pair_class_t pair_cls;

    // Classify the digit-pair sum into one of five values.
    always_comb begin
        if (x_dig.pos && y_dig.pos)
            pair_cls = PAIR_P2;
        else if (x_dig.neg && y_dig.neg)
            pair_cls = PAIR_M2;
        else if ((x_dig.pos && !y_dig.neg && !y_dig.pos) ||
                 (y_dig.pos && !x_dig.neg && !x_dig.pos))
            pair_cls = PAIR_P1;
        else if ((x_dig.neg && !y_dig.neg && !y_dig.pos) ||
                 (y_dig.neg && !x_dig.neg && !x_dig.pos))
            pair_cls = PAIR_M1;
        else
            pair_cls = PAIR_ZERO;
    end

    // Pick transfer and interim so that the later merge can never overflow.
    always_comb begin
        xfer_out = SD_ZERO;
        interim  = SD_ZERO;
        unique case (pair_cls)
            PAIR_P2: xfer_out = SD_PLUS;
            PAIR_M2: xfer_out = SD_MINUS;
            PAIR_P1: begin
                if (!lower_neg) begin
                    xfer_out = SD_PLUS;
                    interim  = SD_MINUS;
                end else begin
                    interim  = SD_PLUS;
                end
            end
            PAIR_M1: begin
                if (lower_neg) begin
                    xfer_out = SD_MINUS;
                    interim  = SD_PLUS;
                end else begin
                    interim  = SD_MINUS;
                end
            end
            default: begin
                xfer_out = SD_ZERO;
                interim  = SD_ZERO;
            end
        endcase
    end

endmodule

// File: rtl/sd_end_around.sv
// End-around path: feeds the transfer out of the top digit and the lookahead
// flag back into digit 0. MOD_PLUS=0 passes both straight (modulus 2^n-1);
// MOD_PLUS=1 negates the transfer and takes the lookahead from the positive
// bits of the top digits, which turn negative after the wrap (modulus 2^n+1).
module sd_end_around
    import sd_mod_pkg::*;
#(
    parameter int MOD_PLUS = 0
) (
    input  sd_digit_t top_xfer,
    input  sd_digit_t top_x,
    input  sd_digit_t top_y,
    output sd_digit_t wrap_xfer,
    output logic      wrap_lower_neg
);

    generate
        if (MOD_PLUS != 0) begin : g_plus
            // Wrapped weight 2^n equals -1 modulo 2^n+1.
            always_comb begin
                wrap_xfer      = sd_negate(top_xfer);
                wrap_lower_neg = top_x.pos | top_y.pos;
            end
        end else begin : g_minus
            // Wrapped weight 2^n equals +1 modulo 2^n-1.
            always_comb begin
                wrap_xfer      = top_xfer;
                wrap_lower_neg = top_x.neg | top_y.neg;
            end
        end
    endgenerate

endmodule

// File: rtl/sd_digit_merge.sv
// Final per-position add of incoming transfer and interim digit. The split
// stage guarantees these never share a nonzero sign, so no carry results.
module sd_digit_merge
    import sd_mod_pkg::*;
(
    input  sd_digit_t xfer_in,
    input  sd_digit_t interim,
    output sd_digit_t sum_dig
);

    logic xfer_zero;
    logic int_zero;

    // Sum of two digits whose total stays within -1..+1.
    always_comb begin
        xfer_zero   = !xfer_in.pos && !xfer_in.neg;
        int_zero    = !interim.pos && !interim.neg;
        sum_dig.pos = (xfer_in.pos && int_zero) || (interim.pos && xfer_zero);
        sum_dig.neg = (xfer_in.neg && int_zero) || (interim.neg && xfer_zero);
    end

    // Guard: the split logic must never hand over a same-sign pair.
    always_comb begin
        p_no_overflow_r1: assert (!((xfer_in.pos && interim.pos) ||
                                    (xfer_in.neg && interim.neg)))
            else $error("transfer and interim share a nonzero sign");
    end

endmodule

// File: rtl/sd_mod_adder.sv
// Carry-free signed-digit adder modulo 2^DIGITS-1 (MOD_PLUS=0) or
// 2^DIGITS+1 (MOD_PLUS=1). Combinational, depth independent of DIGITS.
// Assumes legal digit codes on inputs, DIGITS >= 2; the value checks below
// assume DIGITS <= 30.
module sd_mod_adder
    import sd_mod_pkg::*;
#(
    parameter int DIGITS   = 8,
    parameter int MOD_PLUS = 0
) (
    input  logic [DIGITS-1:0] a_neg,
    input  logic [DIGITS-1:0] a_pos,
    input  logic [DIGITS-1:0] b_neg,
    input  logic [DIGITS-1:0] b_pos,
    output logic [DIGITS-1:0] sum_neg,
    output logic [DIGITS-1:0] sum_pos
);

    localparam int TOP = DIGITS - 1;
    localparam longint MODULUS = (MOD_PLUS != 0) ? ((longint'(1) <<< DIGITS) + 1)
                                                 : ((longint'(1) <<< DIGITS) - 1);

    sd_digit_t [DIGITS-1:0] a_dig;
    sd_digit_t [DIGITS-1:0] b_dig;
    sd_digit_t [DIGITS-1:0] xfer_up;
    sd_digit_t [DIGITS-1:0] interim;
    sd_digit_t [DIGITS-1:0] xfer_in;
    sd_digit_t [DIGITS-1:0] sum_dig;
    logic      [DIGITS-1:0] look_neg;
    sd_digit_t              wrap_xfer;
    logic                   wrap_look;

    // Wrap path from the top digit back to digit 0.
    sd_end_around #(.MOD_PLUS(MOD_PLUS)) u_wrap (
        .top_xfer       (xfer_up[TOP]),
        .top_x          (a_dig[TOP]),
        .top_y          (b_dig[TOP]),
        .wrap_xfer      (wrap_xfer),
        .wrap_lower_neg (wrap_look)
    );

    generate
        for (genvar i = 0; i < DIGITS; i++) begin : g_pos
            // Gather wire pairs into digits and bring results back out.
            assign a_dig[i]   = '{neg: a_neg[i], pos: a_pos[i]};
            assign b_dig[i]   = '{neg: b_neg[i], pos: b_pos[i]};
            assign sum_neg[i] = sum_dig[i].neg;
            assign sum_pos[i] = sum_dig[i].pos;

            if (i == 0) begin : g_low
                assign look_neg[i] = wrap_look;
                assign xfer_in[i]  = wrap_xfer;
            end else begin : g_mid
                assign look_neg[i] = a_neg[i-1] | b_neg[i-1];
                assign xfer_in[i]  = xfer_up[i-1];
            end

            sd_pos_split u_split (
                .x_dig     (a_dig[i]),
                .y_dig     (b_dig[i]),
                .lower_neg (look_neg[i]),
                .xfer_out  (xfer_up[i]),
                .interim   (interim[i])
            );

            sd_digit_merge u_merge (
                .xfer_in (xfer_in[i]),
                .interim (interim[i]),
                .sum_dig (sum_dig[i])
            );
        end
    endgenerate

    logic   in_legal;
    logic   in_zero;
    longint val_diff;

    // Decode operand and result values for the output checks.
    always_comb begin
        in_legal = ((a_neg & a_pos) | (b_neg & b_pos)) == '0;
        in_zero  = (a_neg | a_pos | b_neg | b_pos) == '0;
        val_diff = sd_word_value(64'(sum_neg), 64'(sum_pos))
                 - sd_word_value(64'(a_neg), 64'(a_pos))
                 - sd_word_value(64'(b_neg), 64'(b_pos));
    end

    // Guard the output: legal codes, zero in gives zero out.
    always_comb begin
        if (in_legal) begin
            p_sum_legal_r1: assert ((sum_neg & sum_pos) == '0)
                else $error("illegal output digit code");
            p_zero_sum_r4: assert (!in_zero || ((sum_neg | sum_pos) == '0))
                else $error("zero operands gave nonzero digits");
        end
    end

    generate
        if (MOD_PLUS != 0) begin : g_chk_plus
            // Guard congruence modulo 2^n+1.
            always_comb begin
                if (in_legal) begin
                    p_congruent_plus_r3: assert ((val_diff % MODULUS) == 0)
                        else $error("sum not congruent modulo 2^n+1");
                end
            end
        end else begin : g_chk_minus
            // Guard congruence modulo 2^n-1.
            always_comb begin
                if (in_legal) begin
                    p_congruent_minus_r2: assert ((val_diff % MODULUS) == 0)
                        else $error("sum not congruent modulo 2^n-1");
                end
            end
        end
    endgenerate

endmodule

// File: tb/sd_mod_adder_tb.sv
`timescale 1ns/1ps
module sd_mod_adder_tb;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // 8-digit operands shared by both moduli.
    logic [7:0] a8n = '0, a8p = '0, b8n = '0, b8p = '0;
    logic [7:0] m8n, m8p, p8n, p8p;
    // 3-digit operands shared by both moduli.
    logic [2:0] a3n = '0, a3p = '0, b3n = '0, b3p = '0;
    logic [2:0] m3n, m3p, p3n, p3p;

    sd_mod_adder #(.DIGITS(8), .MOD_PLUS(0)) u_dut (
        .a_neg(a8n), .a_pos(a8p), .b_neg(b8n), .b_pos(b8p),
        .sum_neg(m8n), .sum_pos(m8p));
    sd_mod_adder #(.DIGITS(8), .MOD_PLUS(1)) u_dut_p8 (
        .a_neg(a8n), .a_pos(a8p), .b_neg(b8n), .b_pos(b8p),
        .sum_neg(p8n), .sum_pos(p8p));
    sd_mod_adder #(.DIGITS(3), .MOD_PLUS(0)) u_dut_m3 (
        .a_neg(a3n), .a_pos(a3p), .b_neg(b3n), .b_pos(b3p),
        .sum_neg(m3n), .sum_pos(m3p));
    sd_mod_adder #(.DIGITS(3), .MOD_PLUS(1)) u_dut_p3 (
        .a_neg(a3n), .a_pos(a3p), .b_neg(b3n), .b_pos(b3p),
        .sum_neg(p3n), .sum_pos(p3p));

    // Directed table: operand bits and expected residues mod 255 and mod 257.
    localparam int NVEC = 6;
    localparam logic [7:0] T_AP [NVEC] = '{8'h06, 8'hFF, 8'hFF, 8'h00, 8'h80, 8'hAA};
    localparam logic [7:0] T_AN [NVEC] = '{8'h00, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h55};
    localparam logic [7:0] T_BP [NVEC] = '{8'h02, 8'h01, 8'hFF, 8'h00, 8'h00, 8'h55};
    localparam logic [7:0] T_BN [NVEC] = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'hAA};
    localparam int T_R255 [NVEC] = '{8, 1, 0, 254, 127, 0};
    localparam int T_R257 [NVEC] = '{8, 256, 253, 1, 127, 0};

    function automatic longint wval(input logic [7:0] n, input logic [7:0] p, input int w);
        longint v = 0;
        for (int k = 0; k < w; k++) v = v + (longint'(p[k]) <<< k) - (longint'(n[k]) <<< k);
        return v;
    endfunction

    function automatic longint resid(input longint v, input longint m);
        return ((v % m) + m) % m;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Digit code from 0..2: 0 -> 0, 1 -> +1, 2 -> -1.
    task automatic set3(input int ka, input int kb);
        int da, db;
        for (int j = 0; j < 3; j++) begin
            da = (ka / (3 ** j)) % 3;
            db = (kb / (3 ** j)) % 3;
            a3p[j] = (da == 1); a3n[j] = (da == 2);
            b3p[j] = (db == 1); b3n[j] = (db == 2);
        end
    endtask

    // Operand pair of code values for 8 digits, from random bits.
    task automatic rand8();
        logic [7:0] r;
        r = 8'($urandom); a8p = r; a8n = 8'($urandom) & ~r;
        r = 8'($urandom); b8p = r; b8n = 8'($urandom) & ~r;
    endtask

    task automatic check_mod8(input string tag);
        longint s = wval(a8n, a8p, 8) + wval(b8n, b8p, 8);
        check(resid(wval(m8n, m8p, 8) - s, 255) == 0, {"R2 ", tag}, resid(wval(m8n, m8p, 8), 255), resid(s, 255));
        check(resid(wval(p8n, p8p, 8) - s, 257) == 0, {"R3 ", tag}, resid(wval(p8n, p8p, 8), 257), resid(s, 257));
        check(((m8n & m8p) | (p8n & p8p)) == 0, {"R1 ", tag}, longint'((m8n & m8p) | (p8n & p8p)), 0);
    endtask

    initial begin
        // R4: all-zero operands give all-zero digits (initial state).
        @(posedge clk);
        a8n = '0; a8p = '0; b8n = '0; b8p = '0; a3n = '0; a3p = '0; b3n = '0; b3p = '0;
        @(negedge clk);
        check({m8n, m8p, p8n, p8p} == 0, "R4 zero 8-digit", longint'({m8n, m8p}), 0);
        check({m3n, m3p, p3n, p3p} == 0, "R4 zero 3-digit", longint'({p3n, p3p}), 0);

        // Table walk: directed vectors with precomputed residues (R2, R3).
        for (int t = 0; t < NVEC; t++) begin
            @(posedge clk);
            a8p = T_AP[t]; a8n = T_AN[t]; b8p = T_BP[t]; b8n = T_BN[t];
            @(negedge clk);
            check(resid(wval(m8n, m8p, 8), 255) == T_R255[t], "R2 table", resid(wval(m8n, m8p, 8), 255), T_R255[t]);
            check(resid(wval(p8n, p8p, 8), 257) == T_R257[t], "R3 table", resid(wval(p8n, p8p, 8), 257), T_R257[t]);
        end

        // R5: 6 + 2 modulo 9 comes out as exactly -1.
        @(posedge clk);
        a3p = 3'b110; a3n = '0; b3p = 3'b010; b3n = '0;
        @(negedge clk);
        check(p3n == 3'b001 && p3p == 3'b000, "R5 negative range", wval({5'b0, p3n}, {5'b0, p3p}, 3), -1);
        // R7: 4 + 4 modulo 7 wraps to exactly +1.
        a3p = 3'b100; b3p = 3'b100;
        @(negedge clk);
        check(m3p == 3'b001 && m3n == 3'b000, "R7 end-around", wval({5'b0, m3n}, {5'b0, m3p}, 3), 1);

        // Exhaustive 3-digit sweep under both moduli (R1, R2, R3).
        for (int ka = 0; ka < 27; ka++) begin
            for (int kb = 0; kb < 27; kb++) begin
                longint s, vm, vp;
                @(posedge clk);
                set3(ka, kb);
                @(negedge clk);
                s  = wval({5'b0, a3n}, {5'b0, a3p}, 3) + wval({5'b0, b3n}, {5'b0, b3p}, 3);
                vm = wval({5'b0, m3n}, {5'b0, m3p}, 3);
                vp = wval({5'b0, p3n}, {5'b0, p3p}, 3);
                check(resid(vm - s, 7) == 0, "R2 sweep", resid(vm, 7), resid(s, 7));
                check(resid(vp - s, 9) == 0, "R3 sweep", resid(vp, 9), resid(s, 9));
                check(((m3n & m3p) | (p3n & p3p)) == 0, "R1 sweep", longint'((m3n & m3p) | (p3n & p3p)), 0);
            end
        end

        // Random 8-digit vectors (R1, R2, R3).
        for (int t = 0; t < 400; t++) begin
            @(posedge clk);
            rand8();
            @(negedge clk);
            check_mod8("random");
        end

        // R6 locality: alter one digit of A, far digits must not move.
        for (int rep = 0; rep < 4; rep++) begin
            for (int j = 0; j < 8; j++) begin
                logic [7:0] om_n, om_p, op_n, op_p, keep;
                @(posedge clk);
                rand8();
                @(negedge clk);
                om_n = m8n; om_p = m8p; op_n = p8n; op_p = p8p;
                @(posedge clk);
                if (a8p[j])      begin a8p[j] = 1'b0; a8n[j] = 1'b1; end
                else if (a8n[j]) begin a8n[j] = 1'b0; end
                else             begin a8p[j] = 1'b1; end
                @(negedge clk);
                keep = 8'hFF;
                for (int d = 0; d < 3; d++) keep[(j + d) % 8] = 1'b0;
                check(((m8n ^ om_n) & keep) == 0 && ((m8p ^ om_p) & keep) == 0,
                      "R6 locality minus", longint'({m8n, m8p} & {keep, keep}), longint'({om_n, om_p} & {keep, keep}));
                check(((p8n ^ op_n) & keep) == 0 && ((p8p ^ op_p) & keep) == 0,
                      "R6 locality plus", longint'({p8n, p8p} & {keep, keep}), longint'({op_n, op_p} & {keep, keep}));
                check_mod8("locality");
            end
        end

        // R4 again after activity: zero in gives zero out.
        @(posedge clk);
        a8n = '0; a8p = '0; b8n = '0; b8p = '0;
        @(negedge clk);
        check({m8n, m8p, p8n, p8p} == 0, "R4 zero after traffic", longint'({p8n, p8p}), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule